// File: doc/BRIEF.md
# Configurable Serial-to-Parallel Demultiplexer

This block gathers a serial bit stream into parallel words on a 16-lane bus. It also produces a one-cycle word strobe and a parity bit. The serial stream is modelled as data plus a bit-valid enable sampled on the system clock. Two such pairs arrive at the block: the recovered stream and an external loop-back stream. An active-low selector picks which pair feeds the shifter.

A 2-bit select sets the word length to 16, 10, 8 or 4 bits. The 4-bit word sits on the middle lanes of the bus. The first bit received goes to the highest lane in use, and lanes the ratio does not use stay at 0.

Shaping controls act on the stored word as it leaves the block, so a change takes effect at once. These controls are bus mirroring, odd or even parity, serial-input inversion, parallel-data inversion, word-strobe inversion, and a mute that holds data and parity at 0.

Top module: `ser_demux`

## Requirements
- R1: `ratio_sel_i` selects the word length: 2'b11 gives 16 bits, 2'b10 gives 10, 2'b01 gives 8 and 2'b00 gives 4. A word is completed after exactly that many accepted bits, and a bit is accepted on a clock edge where the selected enable is high.
- R2: Words of 16, 10 and 8 bits occupy lanes N-1..0, and 4-bit words occupy lanes 9..6. The first accepted bit of a word lands on the highest lane in use. Unused lanes read 0.
- R3: The edge that accepts the last bit of a word also updates the data and parity outputs. The word strobe is high for exactly the one following cycle and is low otherwise.
- R4: With `loop_in_n_i` low, the loop-back pair (`lpb_bit_i`, `lpb_en_i`) feeds the shifter. With it high, the recovered pair feeds the shifter. The pair not selected has no effect.
- R5: With `odd_par_i` low, `parity_o` is the XOR of the word bits as received after serial inversion, which is even parity. With `odd_par_i` high, it is the complement.
- R6: With `bus_rev_i` high, lane n of the bus shows what lane 15-n would show otherwise. The change applies combinationally to the current word.
- R7: `ser_inv_i` inverts every incoming serial bit. `par_inv_i` inverts only the lanes in use for the current word. `wclk_inv_i` inverts the word strobe level.
- R8: While `mute_i` is high, `par_data_o` and `parity_o` are 0 and the word strobe keeps running. Releasing mute shows the stored word again.
- R9: When `ratio_sel_i` differs from the ratio in use, the bit count restarts, any bit offered in that cycle is discarded, and no word is emitted until a full word at the new ratio has been collected.
- R10: After reset the data and parity outputs are 0, the strobe is inactive and the ratio in use is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_bit_i | input | 1 | Recovered serial data bit |
| rec_en_i | input | 1 | Recovered bit valid |
| lpb_bit_i | input | 1 | Loop-back serial data bit |
| lpb_en_i | input | 1 | Loop-back bit valid |
| loop_in_n_i | input | 1 | Low selects the loop-back pair |
| ratio_sel_i | input | 2 | Word length select |
| bus_rev_i | input | 1 | Mirror the bus lanes |
| odd_par_i | input | 1 | Odd parity when high |
| ser_inv_i | input | 1 | Invert incoming serial bits |
| par_inv_i | input | 1 | Invert used parallel lanes |
| wclk_inv_i | input | 1 | Invert word strobe |
| mute_i | input | 1 | Force data and parity to 0 |
| par_data_o | output | 16 | Parallel word |
| parity_o | output | 1 | Parity of the word |
| wclk_o | output | 1 | Word strobe |

## Verification
Two events can fall in the same cycle: a ratio change and the arrival of the bit that would complete the current word. The bench provokes this by offering the eighth bit of an 8-bit word on the same edge where the select moves to 10. It then expects no strobe, an unchanged bus, and a word only after ten further bits. The same question is asked in a softer form by changing the ratio in the middle of a 16-bit word, then checking that the strobe stays low after three bits at the new 4-bit ratio and rises on the fourth. A second overlap, mute held high across a word completion, is judged by seeing the strobe fire while data and parity stay at 0.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  localparam int LANES     = 16;
  localparam int CNT_W     = $clog2(LANES + 1);
  localparam int QUAD_BASE = 6;

  typedef enum logic [1:0] {
    RATIO_4  = 2'b00,
    RATIO_8  = 2'b01,
    RATIO_10 = 2'b10,
    RATIO_16 = 2'b11
  } ratio_e;

  function automatic logic [CNT_W-1:0] ratio_len(ratio_e r);
    case (r)
      RATIO_4:  return CNT_W'(4);
      RATIO_8:  return CNT_W'(8);
      RATIO_10: return CNT_W'(10);
      default:  return CNT_W'(16);
    endcase
  endfunction

  function automatic int unsigned lane_base(ratio_e r);
    return (r == RATIO_4) ? QUAD_BASE : 0;
  endfunction

  function automatic logic [LANES-1:0] low_mask(logic [CNT_W-1:0] n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic [LANES-1:0] used_mask(ratio_e r);
    return low_mask(ratio_len(r)) << lane_base(r);
  endfunction

  function automatic logic [LANES-1:0] place_word(logic [LANES-1:0] sr, ratio_e r);
    return (sr & low_mask(ratio_len(r))) << lane_base(r);
  endfunction

  function automatic logic word_parity(logic [LANES-1:0] sr, ratio_e r);
    return ^(sr & low_mask(ratio_len(r)));
  endfunction

  function automatic logic [LANES-1:0] flip_lanes(logic [LANES-1:0] w);
    logic [LANES-1:0] f;
    for (int i = 0; i < LANES; i++) f[i] = w[LANES-1-i];
    return f;
  endfunction

endpackage

// File: rtl/dmx_src_sel.sv
module dmx_src_sel (
  input  logic rec_bit_i,
  input  logic rec_en_i,
  input  logic lpb_bit_i,
  input  logic lpb_en_i,
  input  logic loop_in_n_i,
  input  logic ser_inv_i,
  output logic bit_o,
  output logic en_o
);
  logic use_loop;

  assign use_loop = !loop_in_n_i;
  assign en_o     = use_loop ? lpb_en_i : rec_en_i;
  assign bit_o    = (use_loop ? lpb_bit_i : rec_bit_i) ^ ser_inv_i;
endmodule

// File: rtl/dmx_shifter.sv
module dmx_shifter
  import dmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             en_i,
  input  ratio_e           ratio_i,
  output logic             word_done_o,
  output logic [LANES-1:0] sr_next_o,
  output ratio_e           ratio_q_o
);
  logic [CNT_W-1:0] cnt;
  logic [LANES-1:0] sr;
  ratio_e           ratio_q;
  logic             ratio_chg;
  logic             last_bit;

  assign ratio_chg   = (ratio_i != ratio_q);
  assign last_bit    = (cnt == ratio_len(ratio_q) - CNT_W'(1));
  assign word_done_o = en_i && !ratio_chg && last_bit;
  assign sr_next_o   = {sr[LANES-2:0], bit_i};
  assign ratio_q_o   = ratio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sr      <= '0;
      ratio_q <= RATIO_16;
    end else if (ratio_chg) begin
      cnt     <= '0;
      sr      <= '0;
      ratio_q <= ratio_i;
    end else if (en_i) begin
      sr  <= sr_next_o;
      cnt <= word_done_o ? '0 : cnt + CNT_W'(1);
    end
  end

  // R3: a completed word restarts the count
  a_r3_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o |=> (cnt == '0));

  // R1: the count never reaches the word length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < ratio_len(ratio_q)));

  // R9: a ratio change restarts collection at the new ratio
  a_r9_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_chg |=> ((cnt == '0) && (ratio_q == $past(ratio_i))));
endmodule

// File: rtl/dmx_word_reg.sv
module dmx_word_reg
  import dmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LANES-1:0] sr_i,
  input  ratio_e           ratio_i,
  output logic [LANES-1:0] word_o,
  output logic [LANES-1:0] mask_o,
  output logic             par_o,
  output logic             stb_o
);
  ratio_e wratio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_o <= '0;
      par_o  <= 1'b0;
      stb_o  <= 1'b0;
      wratio <= RATIO_16;
    end else begin
      stb_o <= load_i;
      if (load_i) begin
        word_o <= place_word(sr_i, ratio_i);
        par_o  <= word_parity(sr_i, ratio_i);
        wratio <= ratio_i;
      end
    end
  end

  assign mask_o = used_mask(wratio);

  // R3: the strobe lasts a single cycle
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);
endmodule

// File: rtl/dmx_out_stage.sv
module dmx_out_stage
  import dmx_pkg::*;
(
  input  logic [LANES-1:0] word_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             par_i,
  input  logic             stb_i,
  input  logic             rev_i,
  input  logic             odd_i,
  input  logic             pinv_i,
  input  logic             cinv_i,
  input  logic             mute_i,
  output logic [LANES-1:0] data_o,
  output logic             parity_o,
  output logic             wclk_o
);
  logic [LANES-1:0] ord_word;
  logic [LANES-1:0] ord_mask;

  assign ord_word = rev_i ? flip_lanes(word_i) : word_i;
  assign ord_mask = rev_i ? flip_lanes(mask_i) : mask_i;
  assign data_o   = mute_i ? '0 : (ord_word ^ (pinv_i ? ord_mask : '0));
  assign parity_o = mute_i ? 1'b0 : (par_i ^ odd_i);
  assign wclk_o   = stb_i ^ cinv_i;
endmodule

// File: rtl/ser_demux.sv
module ser_demux
  import dmx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rec_bit_i,
  input  logic        rec_en_i,
  input  logic        lpb_bit_i,
  input  logic        lpb_en_i,
  input  logic        loop_in_n_i,
  input  logic [1:0]  ratio_sel_i,
  input  logic        bus_rev_i,
  input  logic        odd_par_i,
  input  logic        ser_inv_i,
  input  logic        par_inv_i,
  input  logic        wclk_inv_i,
  input  logic        mute_i,
  output logic [15:0] par_data_o,
  output logic        parity_o,
  output logic        wclk_o
);
  logic             ser_bit;
  logic             ser_en;
  logic             word_done;
  logic [LANES-1:0] sr_next;
  ratio_e           ratio_q;
  logic [LANES-1:0] word_q;
  logic [LANES-1:0] mask_q;
  logic             par_q;
  logic             stb_q;

  dmx_src_sel u_src (
    .rec_bit_i  (rec_bit_i),
    .rec_en_i   (rec_en_i),
    .lpb_bit_i  (lpb_bit_i),
    .lpb_en_i   (lpb_en_i),
    .loop_in_n_i(loop_in_n_i),
    .ser_inv_i  (ser_inv_i),
    .bit_o      (ser_bit),
    .en_o       (ser_en)
  );

  dmx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_i      (ser_bit),
    .en_i       (ser_en),
    .ratio_i    (ratio_e'(ratio_sel_i)),
    .word_done_o(word_done),
    .sr_next_o  (sr_next),
    .ratio_q_o  (ratio_q)
  );

  dmx_word_reg u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (word_done),
    .sr_i   (sr_next),
    .ratio_i(ratio_q),
    .word_o (word_q),
    .mask_o (mask_q),
    .par_o  (par_q),
    .stb_o  (stb_q)
  );

  dmx_out_stage u_out (
    .word_i  (word_q),
    .mask_i  (mask_q),
    .par_i   (par_q),
    .stb_i   (stb_q),
    .rev_i   (bus_rev_i),
    .odd_i   (odd_par_i),
    .pinv_i  (par_inv_i),
    .cinv_i  (wclk_inv_i),
    .mute_i  (mute_i),
    .data_o  (par_data_o),
    .parity_o(parity_o),
    .wclk_o  (wclk_o)
  );

  // R5: every used-lane count is even, so inversion and mirroring keep the parity relation
  a_r5_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_i |-> (((^par_data_o) ^ parity_o) == odd_par_i));

  // R8: mute holds data and parity low
  a_r8_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |-> ((par_data_o == '0) && !parity_o));
endmodule

// File: tb/ser_demux_bench.sv
`timescale 1ns/1ps
module ser_demux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_bit = 1'b0, rec_en = 1'b0, lpb_bit = 1'b0, lpb_en = 1'b0;
  logic        loop_in_n = 1'b1;
  logic [1:0]  ratio_sel = 2'b11;
  logic        bus_rev = 1'b0, odd_par = 1'b0, ser_inv = 1'b0, par_inv = 1'b0;
  logic        wclk_inv = 1'b0, mute = 1'b0;
  logic [15:0] par_data;
  logic        parity;
  logic        wclk;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  ser_demux u_ser_demux (
    .clk(clk), .rst_n(rst_n),
    .rec_bit_i(rec_bit), .rec_en_i(rec_en),
    .lpb_bit_i(lpb_bit), .lpb_en_i(lpb_en),
    .loop_in_n_i(loop_in_n), .ratio_sel_i(ratio_sel),
    .bus_rev_i(bus_rev), .odd_par_i(odd_par), .ser_inv_i(ser_inv),
    .par_inv_i(par_inv), .wclk_inv_i(wclk_inv), .mute_i(mute),
    .par_data_o(par_data), .parity_o(parity), .wclk_o(wclk)
  );

  // fields: sel[23:22] rev[21] odd[20] pinv[19] sinv[18] loop[17] spare[16] pattern[15:0]
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h02D7},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h00B4},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h000B},
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0006},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0155},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00F0}
  };

  function automatic int len_of(logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 10;
      default: return 16;
    endcase
  endfunction

  // bench view of the bus: bit k sent (k=0 first) lands on lane base+n-1-k
  function automatic logic [15:0] model_bus(logic [15:0] pat, logic [1:0] s,
                                            logic rev, logic pinv, logic sinv);
    logic [15:0] b = '0;
    logic [15:0] r;
    int n = len_of(s);
    int base = (s == 2'b00) ? 6 : 0;
    for (int k = 0; k < n; k++) b[base + n - 1 - k] = pat[n - 1 - k] ^ sinv ^ pinv;
    if (!rev) return b;
    for (int k = 0; k < 16; k++) r[15 - k] = b[k];
    return r;
  endfunction

  function automatic logic model_par(logic [15:0] pat, logic [1:0] s, logic odd, logic sinv);
    logic p = odd;
    for (int k = 0; k < len_of(s); k++) p ^= pat[k] ^ sinv;
    return p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // sends pat[n-1] first, one idle cycle after every bit; the unselected pair carries junk
  task automatic send_bits(logic [15:0] pat, int n, logic use_lpb);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      rec_en = 1'b1; lpb_en = 1'b1;
      if (use_lpb) begin lpb_bit = pat[i]; rec_bit = ~pat[i]; end
      else         begin rec_bit = pat[i]; lpb_bit = ~pat[i]; end
      @(negedge clk);
      rec_en = 1'b0; lpb_en = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [15:0] pat;
    logic        use_lpb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 data after reset", par_data, 16'h0000);
    check("R10 parity after reset", parity, 1'b0);
    check("R10 strobe after reset", wclk, 1'b0);

    // table walk: R1 R2 R4 R5 R6 R7 R3
    for (int t = 0; t < NV; t++) begin
      v = VEC[t];
      @(negedge clk);
      ratio_sel = v[23:22]; bus_rev = v[21]; odd_par = v[20];
      par_inv = v[19]; ser_inv = v[18]; use_lpb = v[17]; loop_in_n = !v[17];
      pat = v[15:0];
      @(negedge clk);
      send_bits(pat, len_of(v[23:22]), use_lpb);
      check("R3 strobe on completion", wclk, 1'b1);
      check("R1 R2 R4 R6 R7 word", par_data,
            model_bus(pat, v[23:22], v[21], v[19], v[18]));
      check("R5 parity", parity, model_par(pat, v[23:22], v[20], v[18]));
      @(negedge clk);
      check("R3 strobe single cycle", wclk, 1'b0);
    end
    // R6: mirroring acts at once on the stored word
    bus_rev = ~bus_rev;
    #0.5;
    check("R6 mirror toggle", par_data, model_bus(pat, v[23:22], bus_rev, v[19], v[18]));

    // R9: ratio change in mid-word, bit offered in the change cycle discarded
    @(negedge clk);
    bus_rev = 1'b0; odd_par = 1'b0; par_inv = 1'b0; ser_inv = 1'b0;
    loop_in_n = 1'b1; ratio_sel = 2'b11;
    @(negedge clk);
    send_bits(16'h001B, 5, 1'b0);
    @(negedge clk);
    ratio_sel = 2'b00; rec_en = 1'b1; rec_bit = 1'b1;
    @(negedge clk);
    rec_en = 1'b0;
    check("R9 no strobe on change", wclk, 1'b0);
    send_bits(16'h0005, 3, 1'b0);
    check("R9 no word after 3 of 4 bits", wclk, 1'b0);
    send_bits(16'h0000, 1, 1'b0);
    check("R9 strobe after full new word", wclk, 1'b1);
    check("R9 R2 quad word on middle lanes", par_data, 16'h0280);

    // R9: ratio change on the same edge as the completing bit
    @(negedge clk);
    ratio_sel = 2'b01;
    @(negedge clk);
    send_bits(16'h007F, 7, 1'b0);
    @(negedge clk);
    ratio_sel = 2'b10; rec_en = 1'b1; rec_bit = 1'b1;
    @(negedge clk);
    rec_en = 1'b0;
    check("R9 completion suppressed by change", wclk, 1'b0);
    check("R9 bus unchanged", par_data, 16'h0280);
    send_bits(16'h02AB, 10, 1'b0);
    check("R9 strobe at new ratio", wclk, 1'b1);
    check("R9 R1 ten-bit word", par_data, 16'h02AB);
    check("R5 even parity ten-bit", parity, 1'b0);

    // R8: mute
    @(negedge clk);
    mute = 1'b1;
    #0.5;
    check("R8 muted data", par_data, 16'h0000);
    check("R8 muted parity", parity, 1'b0);
    send_bits(16'h0155, 10, 1'b0);
    check("R8 strobe runs under mute", wclk, 1'b1);
    check("R8 data held low at completion", par_data, 16'h0000);
    @(negedge clk);
    mute = 1'b0;
    #0.5;
    check("R8 word back after mute", par_data, 16'h0155);
    check("R8 R5 parity back after mute", parity, 1'b1);

    // R7: strobe inversion
    @(negedge clk);
    wclk_inv = 1'b1;
    #0.5;
    check("R7 inverted strobe idle", wclk, 1'b1);
    send_bits(16'h0321, 10, 1'b0);
    check("R7 inverted strobe active", wclk, 1'b0);
    @(negedge clk);
    check("R7 inverted strobe idle again", wclk, 1'b1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule